// File: doc/BRIEF.md
# Hypervisor Stage-1 Translation Control Register

This block holds the 32-bit control word for the hypervisor's stage-1 address translation. It also judges every coprocessor-style access aimed at that word. A decoded access arrives with its coprocessor number, opcode and register selectors, a read/write flag and write data. The block matches the access against its one encoding. It then checks the current exception level and the security and trap state, and it answers in the same cycle with exactly one outcome:

- a grant, with read data;
- an undefined-instruction indication;
- a trap to the hypervisor, with syndrome code 0x03 and a flag that selects the 32-bit or the 64-bit hypervisor trap path.

A granted write takes effect at the next clock edge.

The stored word is also decoded into effective fields for a table walker:

- the region size as a log2 byte count;
- the inner and outer cacheability;
- the shareability, with a flag for its reserved value;
- the hierarchical-permission disable;
- four hardware-use enables for descriptor bits 59 to 62.

Two optional-feature inputs gate the permission-disable bit and the hardware-use bits. The hardware-use enables are forced to zero unless the permission-disable bit is in effect.

Top module: `hyp_xlat_ctrl`

## Requirements
- R1: Bits 31 and 23 always read as 1. Bits 29, 22:14 and 7:3 always read as 0, and a write to any of these bits has no effect.
- R2: Only the encoding coprocessor 15, opc1 4, CRn 2, CRm 0, opc2 2 is decoded. Any other encoding raises none of grant_o, undef_o or trap_o, and it leaves the register unchanged.
- R3: A decoded access with el_i = 0 raises undef_o and does not write.
- R4: A decoded access with el_i = 1 behaves as follows, and in neither case does it write.
  - When hyp_en_i and hyp_trap_i are both 1, it raises trap_o with trap_ec_o = 0x03 and trap_aa32_o = hyp_aa32_i.
  - Otherwise it raises undef_o.
- R5: A decoded access with el_i = 2 raises grant_o. A read returns the register on rdata_o in the same cycle. A write loads the register at the next rising clock edge.
- R6: A decoded access with el_i = 3 raises undef_o and does not write when ns_i = 0. It raises grant_o when ns_i = 1.
- R7: hpd_eff_o equals bit 24 AND hpd_feat_i. When hpd_feat_i = 0, bit 24 reads as 0.
- R8: hwu_eff_o[k] equals bit 25+k AND hwu_feat_i AND hpd_eff_o. When hwu_feat_i = 0, bits 28:25 read as 0.
- R9: region_log2_o equals 32 minus bits 2:0.
- R10: irgn_o carries bits 9:8, orgn_o carries bits 11:10 and sh_o carries bits 13:12. Shareability codes are 00 non-shareable, 10 outer and 11 inner.
- R11: The reserved shareability code 01 is stored as written, and sh_rsvd_o is 1 exactly when bits 13:12 hold 01.
- R12: After reset, the writable bits (30, 28:24, 13:8, 2:0) hold the matching bits of x3, and bits 31 and 23 hold 1. The value x3 is derived from RST_SEED in three steps: x1 = s ^ (s << 13), then x2 = x1 ^ (x1 >> 17), then x3 = x2 ^ (x2 << 5).
- R13: At most one of grant_o, undef_o and trap_o is 1 in any cycle. Exactly one is 1 for a valid, decoded access. trap_aa32_o is 1 only together with trap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| el_i | input | 2 | Current exception level |
| ns_i | input | 1 | Non-secure state |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_trap_i | input | 1 | Hypervisor trap enable for this register group |
| hyp_aa32_i | input | 1 | Hypervisor runs 32-bit |
| hpd_feat_i | input | 1 | Permission-disable feature present |
| hwu_feat_i | input | 1 | Hardware-use feature present |
| acc_vld_i | input | 1 | Access valid |
| acc_cp_i | input | 4 | Coprocessor number |
| acc_opc1_i | input | 3 | First opcode |
| acc_crn_i | input | 4 | Primary register selector |
| acc_crm_i | input | 4 | Secondary register selector |
| acc_opc2_i | input | 3 | Second opcode |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register value as read |
| grant_o | output | 1 | Access performed |
| undef_o | output | 1 | Undefined instruction |
| trap_o | output | 1 | Trap to hypervisor |
| trap_aa32_o | output | 1 | Trap uses the 32-bit hypervisor path |
| trap_ec_o | output | 6 | Trap syndrome code |
| region_log2_o | output | 6 | log2 of region size in bytes |
| irgn_o | output | 2 | Inner cacheability for walks |
| orgn_o | output | 2 | Outer cacheability for walks |
| sh_o | output | 2 | Shareability for walks |
| sh_rsvd_o | output | 1 | Shareability field holds reserved code |
| hpd_eff_o | output | 1 | Effective permission disable |
| hwu_eff_o | output | 4 | Effective hardware-use enables, bit k for descriptor bit 59+k |

## Verification
The assertions check several rules on every cycle:
- the three response strobes are mutually exclusive;
- the fixed-one and fixed-zero bits hold;
- the trap syndrome is constant;
- the hardware-use outputs depend on the permission disable;
- the region size stays in range;
- the register is stable across cycles without a granted write;
- EL0 and secure EL3 accesses are always routed to undefined.

Only the bench's sweeps show the full routing table over exception level, security, trap and execution-state inputs, and that each encoding mismatch is ignored. They also cover the exact reset pattern, the feature masking of read data and the field-by-field decoding of every value.

// File: rtl/xlat_ctrl_pkg.sv
package xlat_ctrl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EC_W     = 6;
  localparam int unsigned HWU_N    = 4;
  localparam int unsigned HWU_LSB  = 25;
  localparam int unsigned HPD_BIT  = 24;
  localparam int unsigned T0SZ_LSB = 0;
  localparam int unsigned T0SZ_W   = 3;
  localparam int unsigned IRGN_LSB = 8;
  localparam int unsigned ORGN_LSB = 10;
  localparam int unsigned SH_LSB   = 12;
  localparam int unsigned LOG2_W   = 6;
  localparam int unsigned ADDR_W   = 32;

  localparam logic [REG_W-1:0] ONE_MASK = 32'h8080_0000;
  localparam logic [REG_W-1:0] RW_MASK  = 32'h5F00_3F07;
  localparam logic [EC_W-1:0]  TRAP_EC  = 6'h03;
  localparam logic [1:0]       SH_RSVD  = 2'b01;

  typedef enum logic [1:0] {EL0 = 2'd0, EL1 = 2'd1, EL2 = 2'd2, EL3 = 2'd3} el_e;
  typedef enum logic [1:0] {RT_NONE, RT_GRANT, RT_UNDEF, RT_TRAP} route_e;

  typedef struct packed {
    logic [3:0] cp;
    logic [2:0] opc1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] opc2;
  } enc_t;

  localparam enc_t ENC_HIT = '{cp: 4'd15, opc1: 3'd4, crn: 4'd2, crm: 4'd0, opc2: 3'd2};

  function automatic logic [REG_W-1:0] scramble(input logic [REG_W-1:0] s);
    logic [REG_W-1:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction
endpackage

// File: rtl/xlat_acc_route.sv
module xlat_acc_route
  import xlat_ctrl_pkg::*;
(
  input  logic   vld_i,
  input  enc_t   enc_i,
  input  logic [1:0] el_i,
  input  logic   ns_i,
  input  logic   hyp_en_i,
  input  logic   hyp_trap_i,
  output route_e route_o
);
  logic hit;
  assign hit = vld_i && (enc_i == ENC_HIT);

  always_comb begin
    route_o = RT_NONE;
    if (hit) begin
      unique case (el_e'(el_i))
        EL0: route_o = RT_UNDEF;
        EL1: route_o = (hyp_en_i && hyp_trap_i) ? RT_TRAP : RT_UNDEF;
        EL2: route_o = RT_GRANT;
        EL3: route_o = ns_i ? RT_GRANT : RT_UNDEF;
        default: route_o = RT_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/xlat_ctrl_store.sv
module xlat_ctrl_store
  import xlat_ctrl_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_SEED = 32'h1F2E_3D4C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hpd_feat_i,
  input  logic             hwu_feat_i,
  output logic [REG_W-1:0] q_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] RST_VAL = (scramble(RST_SEED) & RW_MASK) | ONE_MASK;
  localparam logic [REG_W-1:0] HPD_M   = REG_W'(1) << HPD_BIT;
  localparam logic [REG_W-1:0] HWU_M   = REG_W'((1 << HWU_N) - 1) << HWU_LSB;

  logic [REG_W-1:0] q;
  logic [REG_W-1:0] gate_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= (wdata_i & RW_MASK) | ONE_MASK;
  end

  // feature-absent fields keep their storage but read as zero
  always_comb begin
    gate_m = '1;
    if (!hpd_feat_i) gate_m &= ~HPD_M;
    if (!hwu_feat_i) gate_m &= ~HWU_M;
  end

  assign q_o     = q;
  assign rdata_o = q & gate_m;
endmodule

// File: rtl/xlat_eff_gen.sv
module xlat_eff_gen
  import xlat_ctrl_pkg::*;
(
  input  logic [REG_W-1:0]  q_i,
  input  logic              hpd_feat_i,
  input  logic              hwu_feat_i,
  output logic [LOG2_W-1:0] region_log2_o,
  output logic [1:0]        irgn_o,
  output logic [1:0]        orgn_o,
  output logic [1:0]        sh_o,
  output logic              sh_rsvd_o,
  output logic              hpd_eff_o,
  output logic [HWU_N-1:0]  hwu_eff_o
);
  logic [T0SZ_W-1:0] t0sz;

  assign t0sz          = q_i[T0SZ_LSB +: T0SZ_W];
  assign region_log2_o = LOG2_W'(ADDR_W) - LOG2_W'(t0sz);
  assign irgn_o        = q_i[IRGN_LSB +: 2];
  assign orgn_o        = q_i[ORGN_LSB +: 2];
  assign sh_o          = q_i[SH_LSB +: 2];
  assign sh_rsvd_o     = (q_i[SH_LSB +: 2] == SH_RSVD);
  assign hpd_eff_o     = q_i[HPD_BIT] & hpd_feat_i;

  for (genvar k = 0; k < HWU_N; k++) begin : g_hwu
    assign hwu_eff_o[k] = q_i[HWU_LSB + k] & hwu_feat_i & hpd_eff_o;
  end
endmodule

// File: rtl/hyp_xlat_ctrl.sv
module hyp_xlat_ctrl
  import xlat_ctrl_pkg::*;
#(
  parameter logic [31:0] RST_SEED = 32'h1F2E_3D4C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  el_i,
  input  logic        ns_i,
  input  logic        hyp_en_i,
  input  logic        hyp_trap_i,
  input  logic        hyp_aa32_i,
  input  logic        hpd_feat_i,
  input  logic        hwu_feat_i,
  input  logic        acc_vld_i,
  input  logic [3:0]  acc_cp_i,
  input  logic [2:0]  acc_opc1_i,
  input  logic [3:0]  acc_crn_i,
  input  logic [3:0]  acc_crm_i,
  input  logic [2:0]  acc_opc2_i,
  input  logic        acc_wr_i,
  input  logic [31:0] acc_wdata_i,
  output logic [31:0] rdata_o,
  output logic        grant_o,
  output logic        undef_o,
  output logic        trap_o,
  output logic        trap_aa32_o,
  output logic [5:0]  trap_ec_o,
  output logic [5:0]  region_log2_o,
  output logic [1:0]  irgn_o,
  output logic [1:0]  orgn_o,
  output logic [1:0]  sh_o,
  output logic        sh_rsvd_o,
  output logic        hpd_eff_o,
  output logic [3:0]  hwu_eff_o
);
  route_e     route;
  enc_t       enc;
  logic [31:0] q;

  assign enc = '{cp: acc_cp_i, opc1: acc_opc1_i, crn: acc_crn_i,
                 crm: acc_crm_i, opc2: acc_opc2_i};

  xlat_acc_route u_route (
    .vld_i      (acc_vld_i),
    .enc_i      (enc),
    .el_i       (el_i),
    .ns_i       (ns_i),
    .hyp_en_i   (hyp_en_i),
    .hyp_trap_i (hyp_trap_i),
    .route_o    (route)
  );

  assign grant_o     = (route == RT_GRANT);
  assign undef_o     = (route == RT_UNDEF);
  assign trap_o      = (route == RT_TRAP);
  assign trap_aa32_o = trap_o & hyp_aa32_i;
  assign trap_ec_o   = TRAP_EC;

  xlat_ctrl_store #(.RST_SEED(RST_SEED)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (grant_o & acc_wr_i),
    .wdata_i    (acc_wdata_i),
    .hpd_feat_i (hpd_feat_i),
    .hwu_feat_i (hwu_feat_i),
    .q_o        (q),
    .rdata_o    (rdata_o)
  );

  xlat_eff_gen u_eff (
    .q_i           (q),
    .hpd_feat_i    (hpd_feat_i),
    .hwu_feat_i    (hwu_feat_i),
    .region_log2_o (region_log2_o),
    .irgn_o        (irgn_o),
    .orgn_o        (orgn_o),
    .sh_o          (sh_o),
    .sh_rsvd_o     (sh_rsvd_o),
    .hpd_eff_o     (hpd_eff_o),
    .hwu_eff_o     (hwu_eff_o)
  );
endmodule

// File: rtl/hyp_xlat_ctrl_chk.sv
module hyp_xlat_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  el_i,
  input logic        ns_i,
  input logic        hyp_en_i,
  input logic        hyp_trap_i,
  input logic        hyp_aa32_i,
  input logic        hpd_feat_i,
  input logic        hwu_feat_i,
  input logic        acc_vld_i,
  input logic [3:0]  acc_cp_i,
  input logic [2:0]  acc_opc1_i,
  input logic [3:0]  acc_crn_i,
  input logic [3:0]  acc_crm_i,
  input logic [2:0]  acc_opc2_i,
  input logic        acc_wr_i,
  input logic [31:0] acc_wdata_i,
  input logic [31:0] rdata_o,
  input logic        grant_o,
  input logic        undef_o,
  input logic        trap_o,
  input logic        trap_aa32_o,
  input logic [5:0]  trap_ec_o,
  input logic [5:0]  region_log2_o,
  input logic [1:0]  irgn_o,
  input logic [1:0]  orgn_o,
  input logic [1:0]  sh_o,
  input logic        sh_rsvd_o,
  input logic        hpd_eff_o,
  input logic [3:0]  hwu_eff_o
);
  logic hit;
  assign hit = acc_vld_i && acc_cp_i == 4'd15 && acc_opc1_i == 3'd4 &&
               acc_crn_i == 4'd2 && acc_crm_i == 4'd0 && acc_opc2_i == 3'd2;

  // R13
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, undef_o, trap_o}));
  // R13
  strobe_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> $countones({grant_o, undef_o, trap_o}) == 1);
  // R13
  aa32_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_aa32_o |-> trap_o);
  // R2
  nohit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> !(grant_o || undef_o || trap_o));
  // R1
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31] && rdata_o[23] && !rdata_o[29] &&
    rdata_o[22:14] == '0 && rdata_o[7:3] == '0);
  // R3
  el0_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && el_i == 2'd0) |-> undef_o);
  // R4
  trap_ec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_ec_o == 6'h03 && el_i == 2'd1 && hyp_en_i && hyp_trap_i));
  // R6
  el3_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && el_i == 2'd3 && !ns_i) |-> undef_o);
  // R5
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && acc_wr_i) |=>
      ((rdata_o & 32'h4000_3F07) == ($past(acc_wdata_i) & 32'h4000_3F07)));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && acc_wr_i) |=> ($stable(region_log2_o) && $stable(sh_o) &&
                                $stable(irgn_o) && $stable(orgn_o)));
  // R8
  hwu_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwu_eff_o != 4'd0) |-> (hpd_eff_o && hwu_feat_i));
  // R7
  hpd_feat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpd_eff_o |-> hpd_feat_i);
  // R9
  region_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_log2_o >= 6'd25 && region_log2_o <= 6'd32);
  // R11
  sh_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_rsvd_o == (sh_o == 2'b01));
endmodule

bind hyp_xlat_ctrl hyp_xlat_ctrl_chk u_chk (.*);

// File: tb/tb_hyp_xlat_ctrl.sv
module tb_hyp_xlat_ctrl;
  localparam logic [31:0] SEED = 32'h1F2E_3D4C;
  localparam logic [31:0] RWM  = 32'h5F00_3F07;
  localparam logic [31:0] ONEM = 32'h8080_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] el_i = 2'd2;
  logic ns_i = 1'b1, hyp_en_i = 1'b0, hyp_trap_i = 1'b0, hyp_aa32_i = 1'b0;
  logic hpd_feat_i = 1'b1, hwu_feat_i = 1'b1;
  logic acc_vld_i = 1'b0, acc_wr_i = 1'b0;
  logic [3:0] acc_cp_i = 4'd15, acc_crn_i = 4'd2, acc_crm_i = 4'd0;
  logic [2:0] acc_opc1_i = 3'd4, acc_opc2_i = 3'd2;
  logic [31:0] acc_wdata_i = '0;
  logic [31:0] rdata_o;
  logic grant_o, undef_o, trap_o, trap_aa32_o, sh_rsvd_o, hpd_eff_o;
  logic [5:0] trap_ec_o, region_log2_o;
  logic [1:0] irgn_o, orgn_o, sh_o;
  logic [3:0] hwu_eff_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mdl;

  always #5 clk_i = ~clk_i;

  hyp_xlat_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] m, input logic hf, input logic wf);
    logic [31:0] r;
    r = m;
    if (!hf) r[24] = 1'b0;
    if (!wf) r[28:25] = 4'd0;
    return r;
  endfunction

  // one access; responses sampled mid-cycle, write lands at the following edge
  task automatic acc(input logic [1:0] el, input logic ns, input logic hen, input logic htr,
                     input logic ha32, input int badf, input logic wr, input logic [31:0] wd,
                     output logic [3:0] rsp, output logic [31:0] rd);
    @(negedge clk_i);
    el_i = el; ns_i = ns; hyp_en_i = hen; hyp_trap_i = htr; hyp_aa32_i = ha32;
    acc_cp_i = (badf == 1) ? 4'd14 : 4'd15;
    acc_opc1_i = (badf == 2) ? 3'd5 : 3'd4;
    acc_crn_i = (badf == 3) ? 4'd3 : 4'd2;
    acc_crm_i = (badf == 4) ? 4'd1 : 4'd0;
    acc_opc2_i = (badf == 5) ? 3'd3 : 3'd2;
    acc_wr_i = wr; acc_wdata_i = wd; acc_vld_i = 1'b1;
    #2;
    rsp = {grant_o, undef_o, trap_o, trap_aa32_o};
    rd = rdata_o;
    @(posedge clk_i);
    #1 acc_vld_i = 1'b0; acc_wr_i = 1'b0;
  endtask

  task automatic wr2(input logic [31:0] wd);
    logic [3:0] r; logic [31:0] d;
    acc(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, wd, r, d);
    mdl = (wd & RWM) | ONEM;
  endtask

  task automatic rd2(output logic [31:0] d);
    logic [3:0] r;
    acc(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 32'd0, r, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0] r;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R12 reset pattern
    mdl = (xs(SEED) & RWM) | ONEM;
    rd2(d);
    chk(d == mdl, "R12 reset", d, mdl);

    // R1 fixed bits under all-ones / all-zeros writes
    wr2(32'hFFFF_FFFF); rd2(d);
    chk(d == 32'hDF80_3F07, "R1 ones", d, 32'hDF80_3F07);
    wr2(32'h0000_0000); rd2(d);
    chk(d == 32'h8080_0000, "R1 zeros", d, 32'h8080_0000);

    // R2 each encoding field mismatched
    for (int b = 1; b <= 5; b++) begin
      acc(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, b, 1'b1, 32'hFFFF_FFFF, r, d);
      chk(r == 4'b0000, "R2 strobes", {28'd0, r}, 32'd0);
      rd2(d);
      chk(d == mdl, "R2 no write", d, mdl);
    end

    // R3 R4 R5 R6 R13 routing sweep
    for (int i = 0; i < 64; i++) begin
      logic [1:0] el; logic ns, hen, htr, ha, wr;
      logic [3:0] er;
      logic [31:0] wd;
      el = i[5:4]; ns = i[3]; hen = i[2]; htr = i[1]; ha = i[0]; wr = ~i[0] | i[3];
      wd = 32'(i) * 32'h9E37_79B9;
      case (el)
        2'd0: er = 4'b0100;
        2'd1: er = (hen && htr) ? {3'b001, ha} : 4'b0100;
        2'd2: er = 4'b1000;
        default: er = ns ? 4'b1000 : 4'b0100;
      endcase
      acc(el, ns, hen, htr, ha, 0, wr, wd, r, d);
      if (el == 2'd0) chk(r == er, "R3 route", {28'd0, r}, {28'd0, er});
      else if (el == 2'd1) chk(r == er && (!r[1] || trap_ec_o == 6'h03), "R4 route", {28'd0, r}, {28'd0, er});
      else if (el == 2'd2) chk(r == er && (wr || d == mdl), "R5 route", {28'd0, r}, {28'd0, er});
      else chk(r == er, "R6 route", {28'd0, r}, {28'd0, er});
      chk($countones(r[3:1]) == 1, "R13 one strobe", {28'd0, r}, 32'd0);
      if (er[3] && wr) mdl = (wd & RWM) | ONEM;
      rd2(d);
      chk(d == mdl, "R5 R6 register after access", d, mdl);
    end

    // R7 R8 feature and permission-disable dependence
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 32; v++) begin
        logic hf, wf, he;
        logic [3:0] we;
        hf = f[0]; wf = f[1];
        wr2({3'd0, 5'(v), 24'd0});
        @(negedge clk_i);
        hpd_feat_i = hf; hwu_feat_i = wf;
        rd2(d);
        chk(d == exp_rd(mdl, hf, wf), "R7 R8 read mask", d, exp_rd(mdl, hf, wf));
        he = v[0] & hf;
        we = 4'(v >> 1) & {4{wf & he}};
        chk(hpd_eff_o == he, "R7 hpd_eff", {31'd0, hpd_eff_o}, {31'd0, he});
        chk(hwu_eff_o == we, "R8 hwu_eff", {28'd0, hwu_eff_o}, {28'd0, we});
        hpd_feat_i = 1'b1; hwu_feat_i = 1'b1;
      end
    end

    // R9 region size
    for (int t = 0; t < 8; t++) begin
      wr2(32'(t));
      @(negedge clk_i);
      chk(region_log2_o == 6'(32 - t), "R9 region", {26'd0, region_log2_o}, 32'(32 - t));
    end

    // R10 R11 attribute fields
    for (int a = 0; a < 64; a++) begin
      logic [5:0] av;
      av = 6'(a);
      wr2({18'd0, av, 8'd0});
      @(negedge clk_i);
      chk({sh_o, orgn_o, irgn_o} == av, "R10 attrs", {26'd0, sh_o, orgn_o, irgn_o}, {26'd0, av});
      chk(sh_rsvd_o == (av[5:4] == 2'b01), "R11 rsvd flag", {31'd0, sh_rsvd_o}, {31'd0, av[5:4] == 2'b01});
      rd2(d);
      chk(d[13:12] == av[5:4], "R11 stored", {30'd0, d[13:12]}, {30'd0, av[5:4]});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule